// File: doc/BRIEF.md
# Wide Vector Shift-Permute Unit

This block reshapes wide vectors on their way from two vector memory read ports to a SIMD compute stage. It holds a small file of full-width vector registers. In every cycle it takes one source vector, which is either of the two memory ports or one of its registers, and passes it through a fixed chain of three slots. The first slot rotates the vector by a byte amount. The second slot either replicates one byte across the vector or compresses adjacent byte blocks for pooling. The third slot either swaps bytes inside small groups or merges the data with a register vector under a byte mask taken from another register. A slot coded as no-operation passes its data through unchanged.

The chain result can be written into any register at the clock edge. Two operand outputs are registered for the compute stage, and each one selects either the chain result or any register. The vector width, register count and rotate range are parameters, so a narrow configuration can be verified and the same code can build a very wide datapath. A simple control bundle drives the unit and no instruction decoding takes place here.

Top module: `vsp_unit`

## Requirements
- R1: While rst_n is low, and after it is released, every register and both operand outputs are zero.
- R2: When wr_en_i is high, the chain result is written into register wr_reg_i at the clock edge. A read of that register in the same cycle returns the value it held before the edge.
- R3: The rotate slot produces output byte i = input byte ((i + rot_amt_i) mod VEC_BYTES), for amounts 0 to 64. Amount 0 passes the data through, and with 64-byte vectors amount 64 also passes the data through.
- R4: With mid_op_i = 1 (replicate), every output byte equals input byte bcast_idx_i.
- R5: With mid_op_i = 2 or 3, output byte j is the unsigned maximum of input bytes 2j..2j+1 or 4j..4j+3 respectively. The results fill the low VEC_BYTES/2 or VEC_BYTES/4 bytes, and all upper bytes are zero.
- R6: With tail_op_i = 1, the two bytes of each aligned pair are exchanged. With tail_op_i = 2, the byte order within each aligned group of four is reversed.
- R7: With tail_op_i = 3 (merge), output byte i is the chain byte when bit 7 of byte i of register mask_reg_i is set, and byte i of register merge_reg_i otherwise.
- R8: The slots apply in the fixed order rotate, then mid (mid_op_i 0 = no-op), then tail (tail_op_i 0 = no-op). Each slot receives the output of the previous slot.
- R9: src_sel_i picks the chain source: 0 for memory port A, 1 for memory port B, and 2 or 3 for register src_reg_i.
- R10: One cycle after the controls are applied, op_a_o holds the chain result when opa_chain_i is high and register opa_reg_i otherwise. op_b_o follows the same rule with opb_chain_i and opb_reg_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| mem_a_i | input | VEC_BYTES*8 | Vector from memory read port A |
| mem_b_i | input | VEC_BYTES*8 | Vector from memory read port B |
| src_sel_i | input | 2 | Chain source select |
| src_reg_i | input | IDX_W | Register used as chain source |
| rot_amt_i | input | ROT_W | Rotate amount in bytes |
| mid_op_i | input | 2 | Mid slot: no-op, replicate, compress-2, compress-4 |
| bcast_idx_i | input | BIDX_W | Byte index to replicate |
| tail_op_i | input | 2 | Tail slot: no-op, swap-2, swap-4, merge |
| merge_reg_i | input | IDX_W | Register supplying unmasked bytes for merge |
| mask_reg_i | input | IDX_W | Register holding the merge byte mask |
| wr_en_i | input | 1 | Write the chain result to a register |
| wr_reg_i | input | IDX_W | Register written |
| opa_chain_i | input | 1 | Operand A takes the chain result |
| opa_reg_i | input | IDX_W | Register for operand A |
| opb_chain_i | input | 1 | Operand B takes the chain result |
| opb_reg_i | input | IDX_W | Register for operand B |
| op_a_o | output | VEC_BYTES*8 | Operand A to the compute stage |
| op_b_o | output | VEC_BYTES*8 | Operand B to the compute stage |

## Verification
The bench builds the unit with its defaults: 64-byte vectors, four registers and a rotate range of 0 to 64. With these values, a rotate by 64 wraps exactly to the identity and a rotate by 63 touches the last byte lane. The compress modes leave 32 or 48 zero bytes at the top, which are easy to observe. Four registers let the source, merge and mask registers differ while a fourth one is written. This makes the same-cycle read-before-write case and the fully chained case reachable alongside a long random run.

// File: rtl/vsp_pkg.sv
package vsp_pkg;

   typedef enum logic [1:0] {
      MID_NOP   = 2'd0,
      MID_BCAST = 2'd1,
      MID_COMP2 = 2'd2,
      MID_COMP4 = 2'd3
   } mid_op_e;

   typedef enum logic [1:0] {
      TAIL_NOP   = 2'd0,
      TAIL_SWAP2 = 2'd1,
      TAIL_SWAP4 = 2'd2,
      TAIL_MERGE = 2'd3
   } tail_op_e;

   typedef enum logic [1:0] {
      SRC_MEM_A = 2'd0,
      SRC_MEM_B = 2'd1,
      SRC_REG   = 2'd2,
      SRC_REG2  = 2'd3
   } src_sel_e;

   function automatic logic [7:0] umax8(input logic [7:0] a, input logic [7:0] b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/vsp_regfile.sv
module vsp_regfile #(
   parameter int NUM_REGS = 4,
   parameter int VEC_BITS = 512,
   parameter int NRD      = 5,
   parameter int IDX_W    = $clog2(NUM_REGS)
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           we,
   input  logic [IDX_W-1:0]               widx,
   input  logic [VEC_BITS-1:0]            wdata,
   input  logic [NRD-1:0][IDX_W-1:0]      rd_idx,
   output logic [NRD-1:0][VEC_BITS-1:0]   rd_data
);

   logic [NUM_REGS-1:0][VEC_BITS-1:0] mem_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_q <= '0;
      end else if (we) begin
         mem_q[widx] <= wdata;
      end
   end

   for (genvar p = 0; p < NRD; p++) begin : g_rd
      assign rd_data[p] = mem_q[rd_idx[p]];
   end

   // R2: written data lands in the addressed register
   a_r2_write_lands : assert property (@(posedge clk) disable iff (!rst_n)
      we |=> mem_q[$past(widx)] == $past(wdata));

   // R2: no write means no register changes
   a_r2_hold : assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(mem_q));

endmodule

// File: rtl/vsp_rotate.sv
module vsp_rotate #(
   parameter int VEC_BYTES = 64,
   parameter int AMT_W     = 7
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [VEC_BYTES*8-1:0] din,
   input  logic [AMT_W-1:0]       amt,
   output logic [VEC_BYTES*8-1:0] dout
);

   localparam int LOG2N  = $clog2(VEC_BYTES);
   localparam int STAGES = (AMT_W < LOG2N) ? AMT_W : LOG2N;

   logic [STAGES:0][VEC_BYTES*8-1:0] stg;

   assign stg[0] = din;

   for (genvar k = 0; k < STAGES; k++) begin : g_stage
      for (genvar i = 0; i < VEC_BYTES; i++) begin : g_byte
         assign stg[k+1][i*8 +: 8] = amt[k]
            ? stg[k][((i + (1 << k)) % VEC_BYTES)*8 +: 8]
            : stg[k][i*8 +: 8];
      end
   end

   if (AMT_W > LOG2N) begin : g_hi
      logic unused_hi_amt;
      assign unused_hi_amt = ^amt[AMT_W-1:LOG2N];
   end

   assign dout = stg[STAGES];

   // R3: a rotation only moves bytes, so the set-bit count is preserved
   a_r3_bits_kept : assert property (@(posedge clk) disable iff (!rst_n)
      $countones(dout) == $countones(din));

endmodule

// File: rtl/vsp_mid.sv
module vsp_mid
   import vsp_pkg::*;
#(
   parameter int VEC_BYTES = 64,
   parameter int BIDX_W    = $clog2(VEC_BYTES)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [VEC_BYTES*8-1:0] din,
   input  logic [1:0]             op,
   input  logic [BIDX_W-1:0]      bidx,
   output logic [VEC_BYTES*8-1:0] dout
);

   localparam int VEC_BITS = VEC_BYTES * 8;
   localparam int HALF     = VEC_BYTES / 2;
   localparam int QUART    = VEC_BYTES / 4;

   logic [HALF-1:0][7:0]  c2;
   logic [QUART-1:0][7:0] c4;
   logic [7:0]            bsel;

   for (genvar j = 0; j < HALF; j++) begin : g_c2
      assign c2[j] = umax8(din[(2*j)*8 +: 8], din[(2*j+1)*8 +: 8]);
   end

   for (genvar j = 0; j < QUART; j++) begin : g_c4
      assign c4[j] = umax8(c2[2*j], c2[2*j+1]);
   end

   assign bsel = din[bidx*8 +: 8];

   always_comb begin
      unique case (mid_op_e'(op))
         MID_BCAST: dout = {VEC_BYTES{bsel}};
         MID_COMP2: dout = {{(VEC_BITS/2){1'b0}}, c2};
         MID_COMP4: dout = {{(VEC_BITS - VEC_BITS/4){1'b0}}, c4};
         default:   dout = din;
      endcase
   end

   // R4: replicate makes every byte equal
   a_r4_uniform : assert property (@(posedge clk) disable iff (!rst_n)
      (op == MID_BCAST) |-> dout == {VEC_BYTES{dout[7:0]}});

   // R5: upper half cleared on pair compression
   a_r5_upper_zero : assert property (@(posedge clk) disable iff (!rst_n)
      (op == MID_COMP2) |-> dout[VEC_BITS-1:VEC_BITS/2] == '0);

   // R5: a pooled byte bounds both of its inputs
   a_r5_max_bound : assert property (@(posedge clk) disable iff (!rst_n)
      (op == MID_COMP2) |-> (dout[7:0] >= din[7:0]) && (dout[7:0] >= din[15:8]));

endmodule

// File: rtl/vsp_tail.sv
module vsp_tail
   import vsp_pkg::*;
#(
   parameter int VEC_BYTES = 64
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [VEC_BYTES*8-1:0] din,
   input  logic [VEC_BYTES*8-1:0] keep_vec,
   input  logic [VEC_BYTES*8-1:0] mask_vec,
   input  logic [1:0]             op,
   output logic [VEC_BYTES*8-1:0] dout
);

   localparam int GROUPS = VEC_BYTES / 4;

   logic [VEC_BYTES*8-1:0] sw2, sw4, mrg;

   for (genvar g = 0; g < GROUPS; g++) begin : g_grp
      localparam int B = 4 * g;
      assign sw2[(B+0)*8 +: 8] = din[(B+1)*8 +: 8];
      assign sw2[(B+1)*8 +: 8] = din[(B+0)*8 +: 8];
      assign sw2[(B+2)*8 +: 8] = din[(B+3)*8 +: 8];
      assign sw2[(B+3)*8 +: 8] = din[(B+2)*8 +: 8];
      assign sw4[(B+0)*8 +: 8] = din[(B+3)*8 +: 8];
      assign sw4[(B+1)*8 +: 8] = din[(B+2)*8 +: 8];
      assign sw4[(B+2)*8 +: 8] = din[(B+1)*8 +: 8];
      assign sw4[(B+3)*8 +: 8] = din[(B+0)*8 +: 8];
   end

   for (genvar i = 0; i < VEC_BYTES; i++) begin : g_mrg
      assign mrg[i*8 +: 8] = mask_vec[i*8 + 7] ? din[i*8 +: 8] : keep_vec[i*8 +: 8];
   end

   always_comb begin
      unique case (tail_op_e'(op))
         TAIL_SWAP2: dout = sw2;
         TAIL_SWAP4: dout = sw4;
         TAIL_MERGE: dout = mrg;
         default:    dout = din;
      endcase
   end

   // R6: byte swaps only move bytes
   a_r6_swap_bits_kept : assert property (@(posedge clk) disable iff (!rst_n)
      ((op == TAIL_SWAP2) || (op == TAIL_SWAP4)) |-> $countones(dout) == $countones(din));

   // R7: merge with all-clear mask yields the keep register
   a_r7_merge_clear : assert property (@(posedge clk) disable iff (!rst_n)
      ((op == TAIL_MERGE) && (mask_vec == '0)) |-> dout == keep_vec);

endmodule

// File: rtl/vsp_unit.sv
module vsp_unit
   import vsp_pkg::*;
#(
   parameter int VEC_BYTES = 64,
   parameter int NUM_REGS  = 4,
   parameter int MAX_ROT   = 64,
   parameter int IDX_W     = $clog2(NUM_REGS),
   parameter int ROT_W     = $clog2(MAX_ROT + 1),
   parameter int BIDX_W    = $clog2(VEC_BYTES)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [VEC_BYTES*8-1:0] mem_a_i,
   input  logic [VEC_BYTES*8-1:0] mem_b_i,
   input  logic [1:0]             src_sel_i,
   input  logic [IDX_W-1:0]       src_reg_i,
   input  logic [ROT_W-1:0]       rot_amt_i,
   input  logic [1:0]             mid_op_i,
   input  logic [BIDX_W-1:0]      bcast_idx_i,
   input  logic [1:0]             tail_op_i,
   input  logic [IDX_W-1:0]       merge_reg_i,
   input  logic [IDX_W-1:0]       mask_reg_i,
   input  logic                   wr_en_i,
   input  logic [IDX_W-1:0]       wr_reg_i,
   input  logic                   opa_chain_i,
   input  logic [IDX_W-1:0]       opa_reg_i,
   input  logic                   opb_chain_i,
   input  logic [IDX_W-1:0]       opb_reg_i,
   output logic [VEC_BYTES*8-1:0] op_a_o,
   output logic [VEC_BYTES*8-1:0] op_b_o
);

   localparam int VEC_BITS = VEC_BYTES * 8;
   localparam int NRD      = 5;
   localparam int RP_SRC   = 0;
   localparam int RP_KEEP  = 1;
   localparam int RP_MASK  = 2;
   localparam int RP_OPA   = 3;
   localparam int RP_OPB   = 4;

   if (VEC_BYTES < 4 || (VEC_BYTES % 4) != 0 || (1 << BIDX_W) != VEC_BYTES) begin : g_bad_width
      $error("vsp_unit: VEC_BYTES must be a power of two of at least 4");
   end
   if (NUM_REGS < 3 || (1 << IDX_W) != NUM_REGS) begin : g_bad_regs
      $error("vsp_unit: NUM_REGS must be a power of two of at least 4");
   end
   if (MAX_ROT < 1) begin : g_bad_rot
      $error("vsp_unit: MAX_ROT must be positive");
   end

   logic [NRD-1:0][IDX_W-1:0]    rd_idx;
   logic [NRD-1:0][VEC_BITS-1:0] rd_data;
   logic [VEC_BITS-1:0]          src_vec, rot_vec, mid_vec, chain_res;
   logic [VEC_BITS-1:0]          op_a_q, op_b_q;

   assign rd_idx[RP_SRC]  = src_reg_i;
   assign rd_idx[RP_KEEP] = merge_reg_i;
   assign rd_idx[RP_MASK] = mask_reg_i;
   assign rd_idx[RP_OPA]  = opa_reg_i;
   assign rd_idx[RP_OPB]  = opb_reg_i;

   vsp_regfile #(
      .NUM_REGS (NUM_REGS),
      .VEC_BITS (VEC_BITS),
      .NRD      (NRD),
      .IDX_W    (IDX_W)
   ) u_rf (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (wr_en_i),
      .widx    (wr_reg_i),
      .wdata   (chain_res),
      .rd_idx  (rd_idx),
      .rd_data (rd_data)
   );

   always_comb begin
      unique case (src_sel_e'(src_sel_i))
         SRC_MEM_A: src_vec = mem_a_i;
         SRC_MEM_B: src_vec = mem_b_i;
         default:   src_vec = rd_data[RP_SRC];
      endcase
   end

   vsp_rotate #(
      .VEC_BYTES (VEC_BYTES),
      .AMT_W     (ROT_W)
   ) u_rot (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (src_vec),
      .amt   (rot_amt_i),
      .dout  (rot_vec)
   );

   vsp_mid #(
      .VEC_BYTES (VEC_BYTES),
      .BIDX_W    (BIDX_W)
   ) u_mid (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (rot_vec),
      .op    (mid_op_i),
      .bidx  (bcast_idx_i),
      .dout  (mid_vec)
   );

   vsp_tail #(
      .VEC_BYTES (VEC_BYTES)
   ) u_tail (
      .clk      (clk),
      .rst_n    (rst_n),
      .din      (mid_vec),
      .keep_vec (rd_data[RP_KEEP]),
      .mask_vec (rd_data[RP_MASK]),
      .op       (tail_op_i),
      .dout     (chain_res)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_a_q <= '0;
         op_b_q <= '0;
      end else begin
         op_a_q <= opa_chain_i ? chain_res : rd_data[RP_OPA];
         op_b_q <= opb_chain_i ? chain_res : rd_data[RP_OPB];
      end
   end

   assign op_a_o = op_a_q;
   assign op_b_o = op_b_q;

   // R10: chain selection reaches operand A one cycle later
   a_r10_opa_chain : assert property (@(posedge clk) disable iff (!rst_n)
      opa_chain_i |=> op_a_o == $past(chain_res));

   // R10: register selection reaches operand B one cycle later
   a_r10_opb_reg : assert property (@(posedge clk) disable iff (!rst_n)
      !opb_chain_i |=> op_b_o == $past(rd_data[RP_OPB]));

   // R8: all slots idle with zero rotate passes the source untouched
   a_r8_idle_pass : assert property (@(posedge clk) disable iff (!rst_n)
      (rot_amt_i == '0 && mid_op_i == 2'd0 && tail_op_i == 2'd0) |-> chain_res == src_vec);

endmodule

// File: tb/vsp_unit_tb_top.sv
module vsp_unit_tb_top;

   localparam int N  = 64;
   localparam int VB = N * 8;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [VB-1:0] mem_a, mem_b;
   logic [1:0]    src_sel;
   logic [1:0]    src_reg;
   logic [6:0]    rot_amt;
   logic [1:0]    mid_op;
   logic [5:0]    bcast_idx;
   logic [1:0]    tail_op;
   logic [1:0]    merge_reg, mask_reg;
   logic          wr_en;
   logic [1:0]    wr_reg;
   logic          opa_chain, opb_chain;
   logic [1:0]    opa_reg, opb_reg;
   logic [VB-1:0] op_a, op_b;

   int checks = 0;
   int fails  = 0;
   logic [VB-1:0] mreg [4];

   always #10 clk = ~clk;

   vsp_unit #(.VEC_BYTES(N), .NUM_REGS(4), .MAX_ROT(64)) dut_i (
      .clk(clk), .rst_n(rst_n), .mem_a_i(mem_a), .mem_b_i(mem_b),
      .src_sel_i(src_sel), .src_reg_i(src_reg), .rot_amt_i(rot_amt),
      .mid_op_i(mid_op), .bcast_idx_i(bcast_idx), .tail_op_i(tail_op),
      .merge_reg_i(merge_reg), .mask_reg_i(mask_reg), .wr_en_i(wr_en),
      .wr_reg_i(wr_reg), .opa_chain_i(opa_chain), .opa_reg_i(opa_reg),
      .opb_chain_i(opb_chain), .opb_reg_i(opb_reg), .op_a_o(op_a), .op_b_o(op_b)
   );

   function automatic logic [VB-1:0] rnd_vec();
      logic [VB-1:0] v;
      for (int k = 0; k < VB/32; k++) v[k*32 +: 32] = $urandom();
      return v;
   endfunction

   function automatic logic [VB-1:0] ramp(input int base);
      logic [VB-1:0] v;
      for (int i = 0; i < N; i++) v[i*8 +: 8] = 8'(base + i);
      return v;
   endfunction

   function automatic logic [VB-1:0] f_rot(input logic [VB-1:0] v, input int amt);
      logic [VB-1:0] r;
      for (int i = 0; i < N; i++) r[i*8 +: 8] = v[((i + amt) % N)*8 +: 8];
      return r;
   endfunction

   function automatic logic [7:0] mx(input logic [7:0] a, input logic [7:0] b);
      return (a > b) ? a : b;
   endfunction

   function automatic logic [VB-1:0] f_mid(input logic [VB-1:0] v, input int op, input int idx);
      logic [VB-1:0] r;
      r = '0;
      case (op)
         1: for (int i = 0; i < N; i++) r[i*8 +: 8] = v[idx*8 +: 8];
         2: for (int j = 0; j < N/2; j++) r[j*8 +: 8] = mx(v[(2*j)*8 +: 8], v[(2*j+1)*8 +: 8]);
         3: for (int j = 0; j < N/4; j++)
               r[j*8 +: 8] = mx(mx(v[(4*j)*8 +: 8], v[(4*j+1)*8 +: 8]),
                                mx(v[(4*j+2)*8 +: 8], v[(4*j+3)*8 +: 8]));
         default: r = v;
      endcase
      return r;
   endfunction

   function automatic logic [VB-1:0] f_tail(input logic [VB-1:0] v, input int op,
                                            input logic [VB-1:0] keep, input logic [VB-1:0] msk);
      logic [VB-1:0] r;
      for (int i = 0; i < N; i++) begin
         case (op)
            1: r[i*8 +: 8] = v[(i ^ 1)*8 +: 8];
            2: r[i*8 +: 8] = v[(i ^ 3)*8 +: 8];
            3: r[i*8 +: 8] = msk[i*8 + 7] ? v[i*8 +: 8] : keep[i*8 +: 8];
            default: r[i*8 +: 8] = v[i*8 +: 8];
         endcase
      end
      return r;
   endfunction

   task automatic chk(input string tag, input logic [VB-1:0] act, input logic [VB-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic idle();
      src_sel = 2'd0; src_reg = 2'd0; rot_amt = '0; mid_op = 2'd0; bcast_idx = '0;
      tail_op = 2'd0; merge_reg = 2'd0; mask_reg = 2'd0; wr_en = 1'b0; wr_reg = 2'd0;
      opa_chain = 1'b1; opa_reg = 2'd0; opb_chain = 1'b0; opb_reg = 2'd0;
   endtask

   // apply current controls for one cycle, then check both operands
   task automatic step(input string tag);
      logic [VB-1:0] src, chain, ea, eb;
      case (src_sel)
         2'd0: src = mem_a;
         2'd1: src = mem_b;
         default: src = mreg[src_reg];
      endcase
      chain = f_tail(f_mid(f_rot(src, int'(rot_amt)), int'(mid_op), int'(bcast_idx)),
                     int'(tail_op), mreg[merge_reg], mreg[mask_reg]);
      ea = opa_chain ? chain : mreg[opa_reg];
      eb = opb_chain ? chain : mreg[opb_reg];
      @(posedge clk);
      if (wr_en) mreg[wr_reg] = chain;
      @(negedge clk);
      chk({tag, " opA"}, op_a, ea);
      chk({tag, " opB"}, op_b, eb);
   endtask

   task automatic load_reg(input int r, input logic [VB-1:0] v);
      idle();
      mem_a = v; wr_en = 1'b1; wr_reg = 2'(r);
      step("R2 load");
   endtask

   initial begin
      void'($urandom(32'd7321));
      rst_n = 1'b0;
      mem_a = '0; mem_b = '0;
      idle();
      for (int r = 0; r < 4; r++) mreg[r] = '0;
      repeat (3) @(negedge clk);
      chk("R1 reset opA", op_a, '0);
      chk("R1 reset opB", op_b, '0);
      rst_n = 1'b1;

      // R1: all registers read back zero after reset
      for (int r = 0; r < 4; r++) begin
         idle(); opa_chain = 1'b0; opa_reg = 2'(r); opb_reg = 2'(r);
         step("R1 reg");
      end

      // R9: sources
      mem_a = ramp(0); mem_b = ramp(100);
      idle(); src_sel = 2'd0; step("R9 memA");
      idle(); src_sel = 2'd1; step("R9 memB");

      // R2: same-cycle read returns old value, then new
      idle(); src_sel = 2'd1; wr_en = 1'b1; wr_reg = 2'd1; opa_chain = 1'b0; opa_reg = 2'd1;
      step("R2 old");
      idle(); opa_chain = 1'b0; opa_reg = 2'd1; step("R2 new");
      idle(); src_sel = 2'd2; src_reg = 2'd1; step("R9 reg");
      idle(); src_sel = 2'd3; src_reg = 2'd1; step("R9 reg alt");

      // R3: rotate amounts
      mem_a = ramp(0);
      foreach (rot_amt_list[k]) begin
         idle(); rot_amt = 7'(rot_amt_list[k]); step("R3 rotate");
      end

      // R4: replicate extremes
      mem_a = rnd_vec();
      idle(); mid_op = 2'd1; bcast_idx = 6'd0;  step("R4 bcast lo");
      idle(); mid_op = 2'd1; bcast_idx = 6'd63; step("R4 bcast hi");

      // R5: compression
      mem_a = rnd_vec(); mem_a[7:0] = 8'hFF; mem_a[31:24] = 8'h80;
      idle(); mid_op = 2'd2; step("R5 comp2");
      idle(); mid_op = 2'd3; step("R5 comp4");

      // R6: swaps
      mem_a = ramp(0);
      idle(); tail_op = 2'd1; step("R6 swap2");
      idle(); tail_op = 2'd2; step("R6 swap4");

      // R7: merge with mask in reg2 and keep data in reg3
      load_reg(2, rnd_vec());
      load_reg(3, rnd_vec());
      mem_a = rnd_vec(); mem_b = '0;
      idle(); tail_op = 2'd3; merge_reg = 2'd3; mask_reg = 2'd2; step("R7 merge");
      load_reg(0, '0);
      idle(); tail_op = 2'd3; merge_reg = 2'd3; mask_reg = 2'd0; step("R7 merge clear");

      // R8: full chain and R10 mixed operand selection
      mem_b = rnd_vec();
      idle(); src_sel = 2'd1; rot_amt = 7'd5; mid_op = 2'd3; tail_op = 2'd1;
      opb_chain = 1'b0; opb_reg = 2'd3; step("R8 chain");
      idle(); src_sel = 2'd1; rot_amt = 7'd17; mid_op = 2'd1; bcast_idx = 6'd9;
      tail_op = 2'd3; merge_reg = 2'd3; mask_reg = 2'd2; opb_chain = 1'b1; step("R10 both chain");

      // R8: random mix
      for (int t = 0; t < 400; t++) begin
         mem_a = rnd_vec(); mem_b = rnd_vec();
         src_sel = 2'($urandom_range(0, 3)); src_reg = 2'($urandom_range(0, 3));
         rot_amt = 7'($urandom_range(0, 64)); mid_op = 2'($urandom_range(0, 3));
         bcast_idx = 6'($urandom_range(0, 63)); tail_op = 2'($urandom_range(0, 3));
         merge_reg = 2'($urandom_range(0, 3)); mask_reg = 2'($urandom_range(0, 3));
         wr_en = 1'($urandom_range(0, 1)); wr_reg = 2'($urandom_range(0, 3));
         opa_chain = 1'($urandom_range(0, 1)); opa_reg = 2'($urandom_range(0, 3));
         opb_chain = 1'($urandom_range(0, 1)); opb_reg = 2'($urandom_range(0, 3));
         step("R8 random");
      end

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   int rot_amt_list [5] = '{0, 1, 31, 63, 64};

   initial begin
      repeat (100000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule